// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, A and B, through a transceiver path that either passes live data or replays a stored word. Each direction owns a holding register. The A-to-B register samples the A bus on the rising edge of its own capture clock. The B-to-A register samples the B bus on the rising edge of a second capture clock. Neither register is reset. Both keep sampling whatever the output controls are doing. A word can therefore be parked while the drivers are off and sent later in either direction.

The datapath is split into lanes, by default two lanes of 8 bits. Each lane has its own capture clocks, its own active-low output enable, its own direction input and its own pair of source selects. Tying the controls of all lanes together makes the block act as one full-width unit. Each bus is modelled as an input value, an output value and a per-lane drive flag, in place of a real tri-state pin.

Top module: `dual_path_xcvr`

## Requirements
- R1: When a lane's `oe_n` is 1, neither `a_drv` nor `b_drv` of that lane is set. The output value of any lane bus that is not driven reads as zero.
- R2: When a lane's `oe_n` is 0 and its `dir` is 1, that lane drives the B bus (`b_drv`=1) and does not drive the A bus (`a_drv`=0).
- R3: When a lane's `oe_n` is 0 and its `dir` is 0, that lane drives the A bus (`a_drv`=1) and does not drive the B bus (`b_drv`=0).
- R4: A select value of 0 passes live data. On a driven B bus with `sel_ab`=0, the lane's `b_out` bits equal its `a_in` bits. On a driven A bus with `sel_ba`=0, the lane's `a_out` bits equal its `b_in` bits.
- R5: On a driven B bus with `sel_ab`=1, the lane's `b_out` bits equal the value of `a_in` that was present at the latest rising edge of that lane's `clk_ab`.
- R6: On a driven A bus with `sel_ba`=1, the lane's `a_out` bits equal the value of `b_in` that was present at the latest rising edge of that lane's `clk_ba`.
- R7: Both registers capture on their clock edges whatever the values of `oe_n`, `dir` and the selects, including during isolation.
- R8: Lane k covers bits [k*8 +: 8] in the default build. Its controls and capture clocks have no effect on the bits, drive flags or stored words of any other lane.
- R9: `a_drv` and `b_drv` of a lane are never set at the same time.
- R10: A stored word does not change when its source bus changes between capture edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | LANES | Per-lane capture clock of the A-to-B register |
| clk_ba | input | LANES | Per-lane capture clock of the B-to-A register |
| oe_n | input | LANES | Per-lane output enable, active low |
| dir | input | LANES | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | LANES | Per-lane B-bus source: 0 live A, 1 stored A-to-B |
| sel_ba | input | LANES | Per-lane A-bus source: 0 live B, 1 stored B-to-A |
| a_in | input | WIDTH | Value present on the A bus |
| a_out | output | WIDTH | Value the block places on the A bus |
| a_drv | output | LANES | Per-lane drive flag of the A bus |
| b_in | input | WIDTH | Value present on the B bus |
| b_out | output | WIDTH | Value the block places on the B bus |
| b_drv | output | LANES | Per-lane drive flag of the B bus |

## Verification
The bench uses the default build: WIDTH 16 and LANES 2, which gives four control bits per lane. Because the control set is this small, the bench can sweep all 256 joint control settings of both lanes against two complementary data patterns. Every pairing of live and stored source, direction and enable in one lane is then seen next to every setting of the other lane, which exposes any leak between lanes. Separate steps capture words during isolation and while the bus is driven, pulse the clock of one lane only, and move the source bus after a capture.

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int WIDTH = 16,
  parameter int LANES = 2,
  localparam int LW = WIDTH / LANES
) (
  input  logic [LANES-1:0] clk_ab,
  input  logic [LANES-1:0] clk_ba,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [LANES-1:0] a_drv,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [LANES-1:0] b_drv
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] ab_q;
    logic [LW-1:0] ba_q;
    logic [LW-1:0] to_b;
    logic [LW-1:0] to_a;

    always_ff @(posedge clk_ab[g]) ab_q <= a_in[g*LW +: LW];
    always_ff @(posedge clk_ba[g]) ba_q <= b_in[g*LW +: LW];

    assign to_b = sel_ab[g] ? ab_q : a_in[g*LW +: LW];
    assign to_a = sel_ba[g] ? ba_q : b_in[g*LW +: LW];

    assign b_drv[g] = ~oe_n[g] & dir[g];
    assign a_drv[g] = ~oe_n[g] & ~dir[g];

    assign b_out[g*LW +: LW] = b_drv[g] ? to_b : '0;
    assign a_out[g*LW +: LW] = a_drv[g] ? to_a : '0;

    always_comb begin
      AST_ONE_SIDE: assert ((a_drv[g] & b_drv[g]) !== 1'b1) else $error("both buses driven"); // R9
      AST_ISOLATED: assert (!(oe_n[g] === 1'b1) || (a_drv[g] === 1'b0 && b_drv[g] === 1'b0)) else $error("driven in isolation"); // R1
      AST_LIVE_B: assert (!(b_drv[g] === 1'b1 && sel_ab[g] === 1'b0) || b_out[g*LW +: LW] === a_in[g*LW +: LW]) else $error("live B mismatch"); // R4
      AST_LIVE_A: assert (!(a_drv[g] === 1'b1 && sel_ba[g] === 1'b0) || a_out[g*LW +: LW] === b_in[g*LW +: LW]) else $error("live A mismatch"); // R4
      AST_QUIET_A: assert (a_drv[g] === 1'b1 || a_out[g*LW +: LW] === '0) else $error("undriven A nonzero"); // R1
    end
  end

endmodule

// File: tb/test_dual_path_xcvr.sv
`timescale 1ns/1ps
module test_dual_path_xcvr;
  localparam int W = 16;
  localparam int L = 2;
  localparam int LW = W / L;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [L-1:0] clk_ab = '0, clk_ba = '0, oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic [L-1:0] a_drv, b_drv;

  dual_path_xcvr #(.WIDTH(W), .LANES(L)) i_dual_path_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out),
    .a_drv(a_drv), .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [LW-1:0] m_ab [L];
  logic [LW-1:0] m_ba [L];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab(input int l);
    clk_ab[l] = 1'b1; #2; clk_ab[l] = 1'b0; #2;
    m_ab[l] = a_in[l*LW +: LW];
  endtask

  task automatic pulse_ba(input int l);
    clk_ba[l] = 1'b1; #2; clk_ba[l] = 1'b0; #2;
    m_ba[l] = b_in[l*LW +: LW];
  endtask

  task automatic check_lane(input int l);
    logic eb, ea;
    logic [LW-1:0] xb, xa;
    eb = !oe_n[l] && dir[l];
    ea = !oe_n[l] && !dir[l];
    xb = eb ? (sel_ab[l] ? m_ab[l] : a_in[l*LW +: LW]) : '0;
    xa = ea ? (sel_ba[l] ? m_ba[l] : b_in[l*LW +: LW]) : '0;
    chk(oe_n[l] ? "R1" : (dir[l] ? "R2" : "R3"), {30'd0, a_drv[l], b_drv[l]}, {30'd0, ea, eb});
    chk("R9", 32'(a_drv[l] & b_drv[l]), 32'd0);
    chk(eb ? (sel_ab[l] ? "R5" : "R4") : "R1", 32'(b_out[l*LW +: LW]), 32'(xb));
    chk(ea ? (sel_ba[l] ? "R6" : "R4") : "R1", 32'(a_out[l*LW +: LW]), 32'(xa));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset-like state: isolated, nothing driven (R1)
    chk("R1", {30'd0, a_drv}, 32'd0);
    chk("R1", {30'd0, b_drv}, 32'd0);
    chk("R1", {a_out, b_out}, 32'd0);

    // R7: capture while isolated
    a_in = 16'hA55A; b_in = 16'h1EE1;
    for (int l = 0; l < L; l++) begin pulse_ab(l); pulse_ba(l); end
    a_in = 16'h0000; b_in = 16'hFFFF;
    oe_n = '0; dir = '1; sel_ab = '1;
    @(negedge clk);
    chk("R7", 32'(b_out), 32'h0000A55A);
    dir = '0; sel_ba = '1;
    @(negedge clk);
    chk("R7", 32'(a_out), 32'h00001EE1);

    // R7: capture while driving
    dir = '1; a_in = 16'h7C3B;
    for (int l = 0; l < L; l++) pulse_ab(l);
    a_in = 16'h0000;
    @(negedge clk);
    chk("R7", 32'(b_out), 32'h00007C3B);

    // R8: pulse lane 0 only
    a_in = 16'h9966;
    pulse_ab(0);
    a_in = 16'h0000;
    @(negedge clk);
    chk("R8", 32'(b_out[15:8]), 32'h7C);
    chk("R8", 32'(b_out[7:0]), 32'h66);

    // R10: source moves between edges
    a_in = 16'hDEAD; b_in = 16'hBEEF;
    @(negedge clk);
    chk("R10", 32'(b_out), 32'h00007C66);
    dir = '0;
    @(negedge clk);
    chk("R10", 32'(a_out), 32'h00001EE1);

    // full sweep of both lanes' controls
    for (int p = 0; p < 2; p++) begin
      a_in = p ? 16'hC3A5 : 16'h3C5A;
      b_in = p ? 16'h18E7 : 16'hE718;
      for (int c = 0; c < 256; c++) begin
        for (int l = 0; l < L; l++) begin
          oe_n[l]   = c[4*l];
          dir[l]    = c[4*l+1];
          sel_ab[l] = c[4*l+2];
          sel_ba[l] = c[4*l+3];
        end
        @(negedge clk);
        for (int l = 0; l < L; l++) check_lane(l);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule